// File: doc/BRIEF.md
# Postfix Stack Calculator

This block evaluates one arithmetic expression at a time. The expression arrives as a stream of byte tokens in postfix order, one token per accepted beat on a valid/ready handshake. An operand token pushes a small non-negative value onto an internal stack. An operator token takes the two top entries, combines them and pushes the result. A terminator token closes the expression. The block then reports the single remaining entry together with an error flag, and starts the next expression with an empty stack.

Add, subtract and multiply each finish in the cycle that accepts the operator. Raise-to-power runs on a separate unit that multiplies once per cycle. While that unit runs, the block holds its ready output low. All arithmetic is on 32-bit unsigned values and wraps modulo 2^32.

Top module: `postfix_eval`

## Requirements
- R1: A token with bit 7 clear is an operand with value 0..127. It is zero-extended to 32 bits and pushed, so the expression `v, 0xFF` returns `v` with no error.
- R2: Token 0x80 (unit select 000) replaces the two top entries with their sum modulo 2^32.
- R3: Token 0x81 (unit select 001) replaces the two top entries with left minus right. When right is larger than left, the result is 0 and the expression is flagged as erroneous.
- R4: Token 0x82 (unit select 010) replaces the two top entries with the low 32 bits of their product.
- R5: Token 0x83 (unit select 011) replaces the two top entries with left raised to the power right, modulo 2^32. Any base raised to 0 gives 1. The unit performs one multiply per cycle.
- R6: For every operator, the left operand is the entry pushed earlier (the deeper one) and the right operand is the top entry.
- R7: Token 0xFF produces a one-cycle `res_valid` pulse in the cycle after it is accepted. It empties the stack and clears the error state, so the next expression starts fresh.
- R8: An operator that finds fewer than two entries sets the error flag and leaves the stack unchanged.
- R9: The stack holds at most 16 entries. An operand that arrives when the stack is full is dropped and sets the error flag.
- R10: When the terminator arrives with a stack depth other than one, `res_err` is 1 and `res_data` is 0.
- R11: Tokens 0x84 to 0xFE are undefined. Each one sets the error flag and leaves the stack unchanged.
- R12: `tok_ready` is high whenever no power calculation is running. It is low from the cycle after a power operator is accepted until that result is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token on `tok_data` is valid |
| tok_data | input | 8 | Postfix token |
| tok_ready | output | 1 | Block can accept a token this cycle |
| res_valid | output | 1 | One-cycle pulse: result of a finished expression |
| res_data | output | 32 | Result value, held until the next terminator |
| res_err | output | 1 | The finished expression was erroneous |

## Verification
All internal state is visible only when a terminator arrives. A wrong stack pointer, a lost entry or a swapped operand order therefore shows up as a wrong `res_data` or a wrong `res_err` at the terminator that follows. This happens one cycle after that terminator is accepted. The operand sweeps use unequal values on each side, so an operand swap in subtraction or power changes the result. The depth tests (full stack, too few operands, leftover entries) show whether the depth count drifted: any drift shifts the sum or flips the error flag. A stuck power unit shows up as `tok_ready` staying low, which the next token exposes.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [2:0] {
    SEL_ADD = 3'b000,
    SEL_SUB = 3'b001,
    SEL_MUL = 3'b010,
    SEL_POW = 3'b011
  } unit_sel_e;

  typedef enum logic [1:0] {
    TK_OPND,
    TK_ARITH,
    TK_END,
    TK_BAD
  } tok_kind_e;

  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } eval_state_e;

  localparam logic [7:0] TOK_END = 8'hFF;

  function automatic tok_kind_e classify(input logic [7:0] t);
    if (!t[7])                return TK_OPND;
    else if (t == TOK_END)    return TK_END;
    else if (t[6:2] == 5'd0)  return TK_ARITH;
    else                      return TK_BAD;
  endfunction

endpackage

// File: rtl/pfx_alu.sv
module pfx_alu
  import pfx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  unit_sel_e           sel,
  input  logic [DATA_W-1:0]   lhs,
  input  logic [DATA_W-1:0]   rhs,
  output logic [DATA_W-1:0]   y,
  output logic                uflow
);

  always_comb begin
    uflow = 1'b0;
    y     = '0;
    unique case (sel)
      SEL_ADD: y = lhs + rhs;
      SEL_SUB: begin
        if (rhs > lhs) begin
          uflow = 1'b1;
          y     = '0;
        end else begin
          y = lhs - rhs;
        end
      end
      SEL_MUL: y = lhs * rhs;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/pfx_pow.sv
module pfx_pow #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] expo,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      acc_q  <= '0;
      base_q <= '0;
      rem_q  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      acc_q  <= DATA_W'(1);
      base_q <= base;
      rem_q  <= expo;
    end else if (busy) begin
      if (rem_q == '0) begin
        busy <= 1'b0;
      end else begin
        acc_q <= acc_q * base_q;
        rem_q <= rem_q - DATA_W'(1);
      end
    end
  end

  assign done   = busy && (rem_q == '0);
  assign result = acc_q;

  // R5
  zero_expo_chk: assert property (@(posedge clk) disable iff (rst)
    (start && expo == '0) |=> done);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

endmodule

// File: rtl/pfx_stack.sv
module pfx_stack #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_val,
  input  logic              reduce,
  input  logic [DATA_W-1:0] reduce_val,
  input  logic              clear,
  output logic [DATA_W-1:0] tos,
  output logic [DATA_W-1:0] nos,
  output logic [CNT_W-1:0]  cnt
);

  // Entries below the top; single write port, one read port.
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_idx;
  logic [AW-1:0]     rd_idx;

  assign wr_idx = AW'(cnt - CNT_W'(1));
  assign rd_idx = AW'(cnt - CNT_W'(2));
  assign nos    = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push && cnt != '0) mem[wr_idx] <= tos;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tos <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (push) begin
      tos <= push_val;
      cnt <= cnt + CNT_W'(1);
    end else if (reduce) begin
      tos <= reduce_val;
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> cnt < CNT_W'(DEPTH));

  // R8
  reduce_depth_chk: assert property (@(posedge clk) disable iff (rst)
    reduce |-> cnt >= CNT_W'(2));

endmodule

// File: rtl/postfix_eval.sv
module postfix_eval
  import pfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_valid,
  input  logic [7:0]        tok_data,
  output logic              tok_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err
);

  eval_state_e       state_q;
  logic              err_q;
  tok_kind_e         kind;
  unit_sel_e         sel;
  logic              accept;
  logic              push, reduce, clear, pow_start, err_set;
  logic              has_two, is_full;
  logic [DATA_W-1:0] tos, nos, alu_y, pow_res, reduce_val;
  logic              alu_uflow, pow_busy, pow_done;
  logic [CNT_W-1:0]  cnt;

  assign tok_ready = (state_q == ST_IDLE);
  assign accept    = tok_valid && tok_ready;
  assign kind      = classify(tok_data);
  assign sel       = unit_sel_e'(tok_data[2:0]);
  assign has_two   = cnt >= CNT_W'(2);
  assign is_full   = cnt == CNT_W'(DEPTH);

  always_comb begin
    push       = accept && kind == TK_OPND && !is_full;
    clear      = accept && kind == TK_END;
    pow_start  = accept && kind == TK_ARITH && sel == SEL_POW && has_two;
    reduce     = (accept && kind == TK_ARITH && sel != SEL_POW && has_two) || pow_done;
    reduce_val = pow_done ? pow_res : alu_y;
    err_set    = accept && ((kind == TK_OPND && is_full) ||
                            (kind == TK_ARITH && !has_two) ||
                            (kind == TK_BAD) ||
                            (kind == TK_ARITH && sel == SEL_SUB && has_two && alu_uflow));
  end

  pfx_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst),
    .push(push), .push_val(DATA_W'(tok_data[6:0])),
    .reduce(reduce), .reduce_val(reduce_val),
    .clear(clear),
    .tos(tos), .nos(nos), .cnt(cnt)
  );

  pfx_alu #(.DATA_W(DATA_W)) u_alu (
    .sel(sel), .lhs(nos), .rhs(tos), .y(alu_y), .uflow(alu_uflow)
  );

  pfx_pow #(.DATA_W(DATA_W)) u_pow (
    .clk(clk), .rst(rst), .start(pow_start),
    .base(nos), .expo(tos),
    .busy(pow_busy), .done(pow_done), .result(pow_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      err_q     <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= clear;
      if (clear) begin
        res_data <= (cnt == CNT_W'(1)) ? tos : '0;
        res_err  <= err_q || (cnt != CNT_W'(1));
        err_q    <= 1'b0;
      end else if (err_set) begin
        err_q <= 1'b1;
      end
      if (pow_start)     state_q <= ST_BUSY;
      else if (pow_done) state_q <= ST_IDLE;
    end
  end

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(tok_valid && tok_ready && tok_data == TOK_END));

  // R10
  depth_err_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == TK_END && cnt != CNT_W'(1)) |=> (res_err && res_data == '0));

  // R3
  sub_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == TK_ARITH && sel == SEL_SUB && has_two && nos < tos) |=> err_q);

  // R8
  short_op_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == TK_ARITH && !has_two) |=> (err_q && $stable(cnt)));

  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    pow_busy |-> !tok_ready);

endmodule

// File: tb/postfix_eval_tb.sv
module postfix_eval_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tok_valid = 1'b0;
  logic [7:0]  tok_data = 8'h00;
  logic        tok_ready, res_valid, res_err;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  postfix_eval u_dut (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_data(tok_data),
    .tok_ready(tok_ready), .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send(input logic [7:0] t);
    tok_valid = 1'b1;
    tok_data  = t;
    while (!tok_ready) @(negedge clk);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic finish_expr(input string req, input logic [31:0] exp_d, input logic exp_e);
    send(8'hFF);
    check({req, " R7 valid"}, 32'(res_valid), 32'd1);
    check({req, " data"}, res_data, exp_d);
    check({req, " err"}, 32'(res_err), 32'(exp_e));
    @(negedge clk);
    check({req, " R7 pulse"}, 32'(res_valid), 32'd0);
  endtask

  task automatic run2(input string req, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] op, input logic [31:0] exp_d, input logic exp_e);
    send(a); send(b); send(op);
    finish_expr(req, exp_d, exp_e);
  endtask

  task automatic push_pow5();
    send(8'd127);
    for (int k = 0; k < 4; k++) begin send(8'd127); send(8'h82); end
  endtask

  function automatic logic [31:0] ipow(input logic [31:0] b, input int e);
    logic [31:0] r = 32'd1;
    for (int k = 0; k < e; k++) r = r * b;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("reset R12 ready", 32'(tok_ready), 32'd1);
    check("reset R7 valid", 32'(res_valid), 32'd0);
    check("reset data", res_data, 32'd0);
    check("reset err", 32'(res_err), 32'd0);

    // R1: every operand value
    for (int v = 0; v < 128; v++) begin
      send(8'(v));
      finish_expr("R1 operand", 32'(v), 1'b0);
    end

    // R2 R3 R4 R6 sweeps
    for (int a = 0; a < 128; a += 9) begin
      for (int b = 1; b < 128; b += 7) begin
        run2("R2 add", 8'(a), 8'(b), 8'h80, 32'(a + b), 1'b0);
        run2("R3 R6 sub", 8'(a), 8'(b), 8'h81, (a >= b) ? 32'(a - b) : 32'd0, b > a);
        run2("R4 mul", 8'(a), 8'(b), 8'h82, 32'(a * b), 1'b0);
      end
    end

    // R4 wrap and R2 wrap
    push_pow5();
    finish_expr("R4 wrap", ipow(32'd127, 5), 1'b0);
    push_pow5(); push_pow5(); send(8'h80);
    finish_expr("R2 wrap", ipow(32'd127, 5) + ipow(32'd127, 5), 1'b0);

    // R5 R6 R12 power sweep
    for (int b = 0; b < 6; b++) begin
      for (int e = 0; e < 7; e++) begin
        send(8'(b)); send(8'(e)); send(8'h83);
        check("R12 busy", 32'(tok_ready), 32'd0);
        finish_expr("R5 R6 pow", ipow(32'(b), e), 1'b0);
      end
    end
    send(8'd3); send(8'd2); send(8'h83); send(8'd2); send(8'h83);
    finish_expr("R5 chained", 32'd81, 1'b0);
    send(8'd7); send(8'd13); send(8'h83);
    finish_expr("R5 long", ipow(32'd7, 13), 1'b0);

    // Mixed
    send(8'd2); send(8'd3); send(8'd4); send(8'h82); send(8'h80); send(8'd5); send(8'h81);
    finish_expr("R2 R3 R4 mixed", 32'd9, 1'b0);
    send(8'd2); send(8'd3); send(8'h83); send(8'd4); send(8'h82);
    finish_expr("R5 R4 mixed", 32'd32, 1'b0);

    // R8
    send(8'd5); send(8'h80);
    finish_expr("R8 one entry", 32'd5, 1'b1);
    send(8'h83); send(8'd4);
    finish_expr("R8 empty", 32'd4, 1'b1);
    send(8'd9);
    finish_expr("R7 err cleared", 32'd9, 1'b0);

    // R9
    for (int k = 1; k <= 16; k++) send(8'(k));
    for (int k = 0; k < 15; k++) send(8'h80);
    finish_expr("R9 full ok", 32'd136, 1'b0);
    for (int k = 1; k <= 17; k++) send(8'(k));
    for (int k = 0; k < 15; k++) send(8'h80);
    finish_expr("R9 overflow", 32'd136, 1'b1);

    // R10
    send(8'd3); send(8'd4);
    finish_expr("R10 two left", 32'd0, 1'b1);
    finish_expr("R10 empty", 32'd0, 1'b1);

    // R11
    send(8'd6); send(8'h84);
    finish_expr("R11 0x84", 32'd6, 1'b1);
    send(8'd6); send(8'd2); send(8'hFE); send(8'h81);
    finish_expr("R11 0xFE", 32'd4, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule